// File: doc/BRIEF.md
# SMBus Descriptor Ring Master Controller

This block is the register-mapped control half of a descriptor-driven SMBus master. Software writes transaction descriptors into a small local ring. It programs the ring length as entries minus one and then advances a software head index. The block keeps a hardware tail index. While a start bit is set and the tail differs from the head, the block presents the descriptor at the tail to a bus transaction engine and holds a request high until the engine reports done.

When a descriptor finishes, the block writes the engine's status and byte counts back into the descriptor. It then moves the tail forward, wrapping after the programmed last entry, and may raise a completion or error interrupt. A failed descriptor that asks to stop on error halts the ring. A kill command aborts the descriptor in flight, and a soft reset returns the control state to idle without touching the descriptors. Both flags are cleared by writing ones, and the interrupt output is high while either flag is set.

Top module: `smb_ring_master`

## Requirements
- R1: After reset the control, status and ring-size registers read 0, and `eng_req`, `eng_abort` and `irq` are low.
- R2: Register words: 0 general control (bit 3 kill, bit 6 soft reset, self-clearing), 1 master control (bit 0 start, bit 4 error interrupt enable, bits 23:16 head index), 2 master status (bit 0 in-progress, bit 4 error interrupt flag, bit 5 completion interrupt flag, bits 23:16 tail index), 3 ring size (bits 7:0 = entries minus one, a value above MAX_ENTRIES-1 saturates to MAX_ENTRIES-1). Descriptor entry i word w sits at word address 16 + 4*i + w.
- R3: While start is set and tail differs from head, the block raises `eng_req` and in-progress and drives the descriptor at the tail. The fields come from word 0 (byte 0 target address with R/W, byte 1 write length/command, byte 2 read length, byte 3 control) and from the data pointer in words 2 (low) and 3 (high).
- R4: On `eng_done`, descriptor word 1 of that entry becomes {tx count, rx count, retry byte unchanged, status}, with status bit 0 meaning success.
- R5: The tail advances by one per finished descriptor and wraps to 0 after reaching the ring-size value.
- R6: Processing stops when the tail equals the head, and in-progress then falls to 0.
- R7: The completion interrupt flag sets only for a finished descriptor whose control bit 6 is set, and `irq` is high while either flag is set.
- R8: Writing a one to status bit 5 or bit 4 clears that flag, and writing zeros leaves both unchanged.
- R9: A descriptor that fails (status bit 0 clear) with control bit 7 set halts the ring. Start and in-progress clear, the tail still moves past it, no further descriptor is fetched, and the error flag sets if the error interrupt enable is set.
- R10: A failed descriptor without control bit 7 does not stop the ring.
- R11: A kill while a descriptor is in flight pulses `eng_abort`, drops `eng_req`, clears start and in-progress, zeroes that descriptor's status byte and leaves the tail on it.
- R12: A soft reset clears control, status, ring size and tail but keeps the descriptor contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Word address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr` (combinational) |
| eng_req | output | 1 | Descriptor presented to the engine |
| eng_abort | output | 1 | One-cycle abort of the descriptor in flight |
| eng_tgt_rw | output | 8 | Target address and R/W bit |
| eng_wr_len | output | 8 | Write length or command byte |
| eng_rd_len | output | 8 | Read length |
| eng_ctrl | output | 8 | Descriptor control byte |
| eng_dptr | output | 64 | Data buffer pointer |
| eng_done | input | 1 | Engine finished the presented descriptor |
| eng_status | input | 8 | Result status, bit 0 success |
| eng_rx_cnt | input | 8 | Bytes received |
| eng_tx_cnt | input | 8 | Bytes transmitted |
| irq | output | 1 | Interrupt, high while a flag is set |

## Verification
The bench targets tail wrap from the last entry back to 0. A design that compares against the ring length instead of entries minus one would fetch a stale entry or skip one. It runs a failure without stop-on-error to show the ring keeps going, and a stop-on-error failure where any extra fetch of the next pending entry is caught by the scoreboard as an unexpected request. Kill is checked for the tail staying on the killed entry and a zeroed status byte, the two things an implementation that reuses the normal completion path would get wrong. Write-one-to-clear with zero data and soft reset preserving descriptors round out the register corner cases.

// File: rtl/smr_pkg.sv
package smr_pkg;

    // Register word addresses
    localparam int REG_GEN  = 0;
    localparam int REG_CTRL = 1;
    localparam int REG_STAT = 2;
    localparam int REG_SIZE = 3;

    // Bit positions
    localparam int GB_KILL  = 3;
    localparam int GB_SRST  = 6;
    localparam int CB_START = 0;
    localparam int CB_MEIE  = 4;
    localparam int SB_MEIS  = 4;
    localparam int SB_MIS   = 5;
    localparam int DC_INT   = 6;
    localparam int DC_SOE   = 7;
    localparam int DS_OK    = 0;

    // Descriptor word 0
    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] rd_len;
        logic [7:0] wr_len;
        logic [7:0] tgt_rw;
    } desc_cmd_t;

    // Descriptor word 1
    typedef struct packed {
        logic [7:0] tx_cnt;
        logic [7:0] rx_cnt;
        logic [7:0] retry;
        logic [7:0] status;
    } desc_res_t;

    function automatic desc_res_t make_result(desc_res_t old, logic [7:0] st,
                                              logic [7:0] rx, logic [7:0] tx);
        desc_res_t r;
        r.tx_cnt = tx;
        r.rx_cnt = rx;
        r.retry  = old.retry;
        r.status = st;
        return r;
    endfunction

endpackage

// File: rtl/smr_desc_store.sv
module smr_desc_store #(
    parameter int IDX_W  = 2,
    localparam int WORDS = (1 << IDX_W) * 4,
    localparam int MEM_AW = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [MEM_AW-1:0] sw_idx,
    input  logic [31:0]       sw_data,
    output logic [31:0]       sw_q,
    input  logic [IDX_W-1:0]  ent_idx,
    output logic [31:0]       ent_w0,
    output logic [31:0]       ent_w1,
    output logic [63:0]       ent_ptr,
    input  logic              wb_en,
    input  logic [31:0]       wb_data
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else begin
            if (sw_we) mem[sw_idx] <= sw_data;
            // hardware write-back wins over a same-word software write
            if (wb_en) mem[{ent_idx, 2'b01}] <= wb_data;
        end
    end

    assign sw_q    = mem[sw_idx];
    assign ent_w0  = mem[{ent_idx, 2'b00}];
    assign ent_w1  = mem[{ent_idx, 2'b01}];
    assign ent_ptr = {mem[{ent_idx, 2'b11}], mem[{ent_idx, 2'b10}]};
endmodule

// File: rtl/smr_ring_seq.sv
module smr_ring_seq #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] head,
    input  logic [IDX_W-1:0] ring_last,
    input  logic             kill,
    input  logic             eng_done,
    input  logic             stop_err,
    output logic             busy,
    output logic             in_prog,
    output logic [IDX_W-1:0] tail,
    output logic             done_evt,
    output logic             kill_evt
);
    logic [IDX_W-1:0] tail_nxt;
    logic             launch;

    assign tail_nxt = (tail == ring_last) ? '0 : tail + 1'b1;
    assign launch   = start && (tail != head);
    assign kill_evt = busy && kill;
    assign done_evt = busy && eng_done && !kill;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            in_prog <= 1'b0;
            tail    <= '0;
        end else if (busy) begin
            if (kill) begin
                busy    <= 1'b0;
                in_prog <= 1'b0;
            end else if (eng_done) begin
                busy <= 1'b0;
                tail <= tail_nxt;
                if (stop_err || tail_nxt == head) in_prog <= 1'b0;
            end
        end else begin
            busy    <= launch;
            in_prog <= launch;
        end
    end

    // R3: a request is never outstanding without in-progress
    p_req_in_prog_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> in_prog);

    // R5: tail moves only on a finished descriptor
    p_tail_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(tail));

    // R6: caught up means no fetch next cycle
    p_caught_up_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && tail == head) |=> !busy);

    // R11: kill ends the descriptor and keeps the tail
    p_kill_holds_tail_r11: assert property (@(posedge clk) disable iff (rst)
        kill_evt |=> (!busy && !in_prog && $stable(tail)));
endmodule

// File: rtl/smb_ring_master.sv
module smb_ring_master
    import smr_pkg::*;
#(
    parameter int MAX_ENTRIES = 4,
    parameter int ADDR_W      = 6,
    parameter int DESC_BASE   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              eng_req,
    output logic              eng_abort,
    output logic [7:0]        eng_tgt_rw,
    output logic [7:0]        eng_wr_len,
    output logic [7:0]        eng_rd_len,
    output logic [7:0]        eng_ctrl,
    output logic [63:0]       eng_dptr,
    input  logic              eng_done,
    input  logic [7:0]        eng_status,
    input  logic [7:0]        eng_rx_cnt,
    input  logic [7:0]        eng_tx_cnt,
    output logic              irq
);
    localparam int IDX_W      = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
    localparam int DESC_WORDS = (1 << IDX_W) * 4;
    localparam int MEM_AW     = IDX_W + 2;

    logic [IDX_W-1:0]  head_q, ring_last_q, tail;
    logic              start_q, meie_q, mis_q, meis_q;
    logic              busy, in_prog, done_evt, kill_evt, halt_evt;
    logic              wr_gen, wr_ctrl, wr_stat, wr_size, srst, kill, in_win;
    logic [ADDR_W-1:0] win_off;
    logic [31:0]       sw_q, ent_w0, ent_w1, wb_data;
    desc_cmd_t         cmd;
    desc_res_t         res;

    // Register decode
    assign wr_gen  = csr_we && (csr_addr == ADDR_W'(REG_GEN));
    assign wr_ctrl = csr_we && (csr_addr == ADDR_W'(REG_CTRL));
    assign wr_stat = csr_we && (csr_addr == ADDR_W'(REG_STAT));
    assign wr_size = csr_we && (csr_addr == ADDR_W'(REG_SIZE));
    assign srst    = wr_gen && csr_wdata[GB_SRST];
    assign kill    = wr_gen && csr_wdata[GB_KILL];
    assign win_off = csr_addr - ADDR_W'(DESC_BASE);
    assign in_win  = (csr_addr >= ADDR_W'(DESC_BASE)) && (win_off < ADDR_W'(DESC_WORDS));

    assign cmd      = desc_cmd_t'(ent_w0);
    assign res      = desc_res_t'(ent_w1);
    assign halt_evt = done_evt && !eng_status[DS_OK] && cmd.ctrl[DC_SOE];
    assign wb_data  = kill_evt ? make_result(res, 8'h00, res.rx_cnt, res.tx_cnt)
                               : make_result(res, eng_status, eng_rx_cnt, eng_tx_cnt);

    smr_desc_store #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .sw_we   (csr_we && in_win),
        .sw_idx  (win_off[MEM_AW-1:0]),
        .sw_data (csr_wdata),
        .sw_q    (sw_q),
        .ent_idx (tail),
        .ent_w0  (ent_w0),
        .ent_w1  (ent_w1),
        .ent_ptr (eng_dptr),
        .wb_en   (done_evt || kill_evt),
        .wb_data (wb_data)
    );

    smr_ring_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst || srst),
        .start     (start_q),
        .head      (head_q),
        .ring_last (ring_last_q),
        .kill      (kill),
        .eng_done  (eng_done),
        .stop_err  (!eng_status[DS_OK] && cmd.ctrl[DC_SOE]),
        .busy      (busy),
        .in_prog   (in_prog),
        .tail      (tail),
        .done_evt  (done_evt),
        .kill_evt  (kill_evt)
    );

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            start_q     <= 1'b0;
            meie_q      <= 1'b0;
            head_q      <= '0;
            ring_last_q <= '0;
            mis_q       <= 1'b0;
            meis_q      <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                start_q <= csr_wdata[CB_START];
                meie_q  <= csr_wdata[CB_MEIE];
                head_q  <= csr_wdata[16 +: IDX_W];
            end
            if (wr_size)
                ring_last_q <= (csr_wdata[7:0] > 8'(MAX_ENTRIES - 1)) ?
                               IDX_W'(MAX_ENTRIES - 1) : csr_wdata[IDX_W-1:0];
            if (wr_stat && csr_wdata[SB_MIS])  mis_q  <= 1'b0;
            if (wr_stat && csr_wdata[SB_MEIS]) meis_q <= 1'b0;
            if (done_evt && cmd.ctrl[DC_INT])  mis_q  <= 1'b1;
            if (halt_evt) begin
                start_q <= 1'b0;
                if (meie_q) meis_q <= 1'b1;
            end
            if (kill_evt) start_q <= 1'b0;
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (in_win) csr_rdata = sw_q;
        else begin
            case (csr_addr)
                ADDR_W'(REG_CTRL): csr_rdata = {8'h00, 8'(head_q), 11'h000, meie_q, 3'b000, start_q};
                ADDR_W'(REG_STAT): csr_rdata = {8'h00, 8'(tail), 10'h000, mis_q, meis_q, 3'b000, in_prog};
                ADDR_W'(REG_SIZE): csr_rdata = {24'h000000, 8'(ring_last_q)};
                default:           csr_rdata = '0;
            endcase
        end
    end

    assign eng_req    = busy;
    assign eng_abort  = kill_evt;
    assign eng_tgt_rw = cmd.tgt_rw;
    assign eng_wr_len = cmd.wr_len;
    assign eng_rd_len = cmd.rd_len;
    assign eng_ctrl   = cmd.ctrl;
    assign irq        = mis_q || meis_q;

    // R7: completion flag rises only after a finished descriptor asking for it
    p_mis_cause_r7: assert property (@(posedge clk) disable iff (rst || srst)
        $rose(mis_q) |-> $past(done_evt && cmd.ctrl[DC_INT]));

    // R9: stop-on-error failure clears start and in-progress
    p_halt_stops_r9: assert property (@(posedge clk) disable iff (rst)
        (halt_evt && !srst) |=> (!start_q && !in_prog));

    // R11: abort only while a descriptor is in flight
    p_abort_busy_r11: assert property (@(posedge clk) disable iff (rst)
        eng_abort |-> eng_req);
endmodule

// File: tb/smb_ring_master_tb.sv
`timescale 1ns/1ps
module smb_ring_master_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        csr_we;
    logic [5:0]  csr_addr;
    logic [31:0] csr_wdata, csr_rdata;
    logic        eng_req, eng_abort, eng_done, irq;
    logic [7:0]  eng_tgt_rw, eng_wr_len, eng_rd_len, eng_ctrl;
    logic [7:0]  eng_status, eng_rx_cnt, eng_tx_cnt;
    logic [63:0] eng_dptr;

    always #2 clk = ~clk;

    smb_ring_master u_dut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .eng_req(eng_req),
        .eng_abort(eng_abort), .eng_tgt_rw(eng_tgt_rw), .eng_wr_len(eng_wr_len),
        .eng_rd_len(eng_rd_len), .eng_ctrl(eng_ctrl), .eng_dptr(eng_dptr),
        .eng_done(eng_done), .eng_status(eng_status), .eng_rx_cnt(eng_rx_cnt),
        .eng_tx_cnt(eng_tx_cnt), .irq(irq)
    );

    typedef struct {
        logic [31:0] w0;
        logic [63:0] ptr;
        logic [7:0]  st, rx, tx;
    } exp_t;

    exp_t        q[$];
    logic [31:0] w0img [4];
    int          n_chk = 0, n_bad = 0;
    bit          hold_eng = 1'b0, finished = 1'b0;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = 6'(a); csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = 6'(a);
        #1 d = csr_rdata;
    endtask

    task automatic load(input int i, input logic [7:0] tg, wl, rl, ct);
        w0img[i] = {ct, rl, wl, tg};
        wr(16 + i*4, w0img[i]);
        wr(17 + i*4, 32'h0000_3300);
        wr(18 + i*4, 32'h1000_0000 + i);
        wr(19 + i*4, 32'h0000_00A0 + i);
    endtask

    // driver side: push the descriptor the engine should see and its response
    task automatic expect_desc(input int i, input logic [7:0] st, rx, tx);
        exp_t e;
        e.w0 = w0img[i];
        e.ptr = {32'h0000_00A0 + i, 32'h1000_0000 + i};
        e.st = st; e.rx = rx; e.tx = tx;
        q.push_back(e);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 200; k++) begin
            rd(2, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    // monitor / engine model: pops expected items as the design fetches
    initial begin
        exp_t e;
        eng_done = 1'b0; eng_status = '0; eng_rx_cnt = '0; eng_tx_cnt = '0;
        forever begin
            @(negedge clk);
            if (eng_req && !hold_eng) begin
                if (q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R9 unexpected fetch actual=%0h expected=none",
                             {eng_ctrl, eng_rd_len, eng_wr_len, eng_tgt_rw});
                    eng_status = 8'h01;
                end else begin
                    e = q.pop_front();
                    check("R3 descriptor fields", {eng_ctrl, eng_rd_len, eng_wr_len, eng_tgt_rw}, e.w0);
                    check("R3 data pointer", eng_dptr, e.ptr);
                    eng_status = e.st; eng_rx_cnt = e.rx; eng_tx_cnt = e.tx;
                end
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        ab;
        rst = 1'b1; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1, v); check("R1 ctrl reset", v, 0);
        rd(2, v); check("R1 status reset", v, 0);
        rd(3, v); check("R1 size reset", v, 0);
        check("R1 req/abort/irq low", {eng_req, eng_abort, irq}, 0);

        // R2 ring size saturates
        wr(3, 32'h9); rd(3, v); check("R2 size saturates", v, 3);

        load(0, 8'hA4, 8'h11, 8'h02, 8'h40);
        load(1, 8'hB1, 8'h22, 8'h01, 8'h00);
        load(2, 8'hC0, 8'h33, 8'h00, 8'h40);
        load(3, 8'hD1, 8'h44, 8'h05, 8'h80);
        rd(24, v); check("R2 descriptor window", v, w0img[2]);

        // Phase A: two descriptors
        expect_desc(0, 8'h01, 8'h02, 8'h11);
        expect_desc(1, 8'h01, 8'h01, 8'h22);
        wr(1, 32'h0002_0011);
        wait_idle();
        check("R6 queue drained", q.size(), 0);
        rd(1, v); check("R2 ctrl readback", v, 32'h0002_0011);
        rd(2, v); check("R6 R7 status after run", v, 32'h0002_0020);
        check("R7 irq high", irq, 1);
        rd(17, v); check("R4 write-back entry0", v, 32'h1102_3301);
        rd(21, v); check("R4 write-back entry1", v, 32'h2201_3301);

        // Phase B: write-one-to-clear
        wr(2, 32'h0); rd(2, v); check("R8 zero write keeps flag", v, 32'h0002_0020);
        wr(2, 32'h20); rd(2, v); check("R8 W1C clears", v, 32'h0002_0000);
        check("R7 irq low", irq, 0);

        // Phase C: wrap 2,3,0
        expect_desc(2, 8'h01, 8'h00, 8'h33);
        expect_desc(3, 8'h01, 8'h05, 8'h44);
        expect_desc(0, 8'h01, 8'h02, 8'h11);
        wr(1, 32'h0001_0011);
        wait_idle();
        check("R5 queue drained", q.size(), 0);
        rd(2, v); check("R5 tail wrapped", v, 32'h0001_0020);
        wr(2, 32'h20);

        // Phase D: failure without stop-on-error
        expect_desc(1, 8'h08, 8'h00, 8'h22);
        expect_desc(2, 8'h01, 8'h00, 8'h33);
        wr(1, 32'h0003_0011);
        wait_idle();
        check("R10 queue drained", q.size(), 0);
        rd(2, v); check("R10 continued", v, 32'h0003_0020);
        rd(21, v); check("R10 R4 failed status stored", v, 32'h2200_3308);
        wr(2, 32'h20);

        // Phase E: stop-on-error halt (entry 0 must not be fetched)
        expect_desc(3, 8'h10, 8'h00, 8'h01);
        wr(1, 32'h0001_0011);
        wait_idle();
        repeat (10) @(negedge clk);
        check("R9 queue drained", q.size(), 0);
        rd(2, v); check("R9 status halted", v, 32'h0000_0010);
        rd(1, v); check("R9 start cleared", v, 32'h0001_0010);
        check("R9 irq on error", irq, 1);
        rd(17, v); check("R9 entry0 untouched", v, 32'h1102_3301);
        wr(2, 32'h10);
        check("R8 error flag cleared", irq, 0);

        // Phase F: kill
        hold_eng = 1'b1;
        wr(1, 32'h0001_0011);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (eng_req) break;
        end
        check("R11 request up", eng_req, 1);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = 6'd0; csr_wdata = 32'h8;
        #1 ab = eng_abort;
        @(negedge clk);
        csr_we = 1'b0;
        check("R11 abort pulse", ab, 1);
        check("R11 request dropped", {eng_req, eng_abort}, 0);
        hold_eng = 1'b0;
        rd(2, v); check("R11 tail kept, idle", v, 32'h0);
        rd(1, v); check("R11 start cleared", v, 32'h0001_0010);
        rd(17, v); check("R11 status zeroed", v, 32'h1102_3300);

        // Phase G: rerun entry 0 then soft reset
        expect_desc(0, 8'h01, 8'h02, 8'h11);
        wr(1, 32'h0001_0011);
        wait_idle();
        rd(2, v); check("R5 tail after rerun", v, 32'h0001_0020);
        wr(0, 32'h40);
        rd(1, v); check("R12 ctrl cleared", v, 0);
        rd(2, v); check("R12 status cleared", v, 0);
        rd(3, v); check("R12 size cleared", v, 0);
        check("R12 irq low", irq, 0);
        rd(24, v); check("R12 descriptor kept", v, w0img[2]);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule